// File: doc/BRIEF.md
# Preamble and Sync-Word Qualifier

This block sits behind a receive demodulator. It takes the recovered bit stream one bit at a time, with each bit marked by a one-cycle strobe. It looks for a run of alternating bits that marks the start of a frame. Once the run reaches a programmable length, it raises a "preamble seen" level and starts looking for a sync word of one to four bytes. If the sync word arrives, a "sync found" level replaces the preamble level until the packet logic reports the end of the packet. If the sync word does not arrive within a window set by the programmed preamble length, the block drops the preamble level and starts searching again.

While searching, the block also reports that no preamble was found. It raises this flag once for every threshold-length window of bits that passes without a detection. The flag is held off for a settling period of 16 bit strobes after the receiver is switched on. Each event is also reported as a one-cycle pulse, so the block can feed an interrupt controller. Switching the receiver off returns the block to an idle state.

Top module: `preamble_detect`

## Requirements
- R1: While `rst` is high, and in the cycle after any cycle with `rx_en` low, every level and pulse output is 0.
- R2: `pre_valid` and a one-cycle `valid_irq` assert on the strobe at which the current run of alternating bits reaches 4×`thr_nib` bits. Counting starts with the first strobe after searching begins.
- R3: Two equal consecutive strobed bits end the run. The second of the two bits starts a new run of length 1.
- R4: `invalid_irq` never pulses during the first 16 bit strobes after `rx_en` rises.
- R5: While searching, after the settling period, `invalid_irq` pulses once on every 4×`thr_nib`-th strobe with no detection. A detection, or leaving the search, restarts this window.
- R6: While waiting for sync, the last 8×(`sync_bytes`+1) strobed bits are compared with the top bytes of `sync_word`. The byte at bits 31:24 is received first, MSB first. On a match, `sync_found` rises, `pre_valid` falls and `sync_irq` pulses for one cycle.
- R7: If no match occurs within 4×`pre_len_nib`+16 strobes after detection, `pre_valid` falls on the last of those strobes. `timeout_irq` pulses and the search restarts.
- R8: A `pkt_done` pulse while `sync_found` is high clears it in the next cycle and resumes the search.
- R9: Cycles without `bit_vld` change no output, whatever `bit_in` does.
- R10: Every `*_irq` output is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low forces idle |
| bit_vld | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Demodulated data bit |
| pkt_done | input | 1 | End-of-packet pulse |
| thr_nib | input | THR_W (5) | Detection threshold in nibbles (1 or more) |
| pre_len_nib | input | LEN_W (9) | Programmed preamble length in nibbles |
| sync_word | input | 32 | Sync pattern, first byte in bits 31:24 |
| sync_bytes | input | 2 | Sync length in bytes minus one |
| pre_valid | output | 1 | Preamble detected, sync pending |
| sync_found | output | 1 | Sync word matched, packet in progress |
| valid_irq | output | 1 | Pulse on preamble detection |
| invalid_irq | output | 1 | Pulse on a window with no preamble |
| sync_irq | output | 1 | Pulse on sync match |
| timeout_irq | output | 1 | Pulse on sync wait expiry |

## Verification
Some properties are checked on every cycle. The two status levels are never high together. Both levels go quiet after the enable drops. Each pulse lasts exactly one cycle and follows a strobe. A fall of the preamble level always comes with a sync or timeout pulse, or with a loss of enable. No invalid pulse appears before 16 strobes have passed since enable. Other behaviour is shown only by the bench scenarios: the exact strobe index of detection, sync and timeout for different thresholds and sync lengths, a run that restarts on a repeated bit, the positions of the invalid pulses, and an idle gap that has no effect.

// File: rtl/pdet_pkg.sv
package pdet_pkg;
    localparam int SETTLE_BITS = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_SYNC_WAIT,
        ST_SYNC_FOUND
    } pdet_state_e;

    typedef struct packed {
        logic valid;
        logic invalid;
        logic sync;
        logic timeout;
    } pdet_evt_t;
endpackage

// File: rtl/pdet_run_counter.sv
module pdet_run_counter #(
    parameter int THR_W = 5,
    localparam int RUN_W = THR_W + 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic             bit_in,
    input  logic [THR_W-1:0] thr,
    output logic             hit
);
    logic             have_prev;
    logic             prev_bit;
    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] run_nxt;
    logic [RUN_W-1:0] target;

    always_comb begin
        target = RUN_W'({thr, 2'b00});
        if (have_prev && (bit_in != prev_bit)) begin
            run_nxt = (run == {RUN_W{1'b1}}) ? run : run + 1'b1;
        end else begin
            run_nxt = RUN_W'(1);
        end
        hit = step && (run_nxt >= target);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            have_prev <= 1'b0;
            prev_bit  <= 1'b0;
            run       <= '0;
        end else if (step) begin
            have_prev <= 1'b1;
            prev_bit  <= bit_in;
            run       <= run_nxt;
        end
    end
endmodule

// File: rtl/pdet_window.sv
module pdet_window #(
    parameter int THR_W  = 5,
    parameter int SETTLE = pdet_pkg::SETTLE_BITS,
    localparam int WIN_W = THR_W + 2,
    localparam int BLK_W = $clog2(SETTLE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             clr_win,
    input  logic             strobe,
    input  logic             step,
    input  logic [THR_W-1:0] thr,
    output logic             fire
);
    logic [BLK_W-1:0] blank_cnt;
    logic             blank_done;
    logic [WIN_W-1:0] win_cnt;
    logic [WIN_W-1:0] win_nxt;

    always_comb begin
        blank_done = (blank_cnt == BLK_W'(SETTLE));
        win_nxt    = win_cnt + 1'b1;
        fire       = step && blank_done && (win_nxt == {thr, 2'b00});
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            blank_cnt <= '0;
            win_cnt   <= '0;
        end else begin
            if (strobe && !blank_done) begin
                blank_cnt <= blank_cnt + 1'b1;
            end
            if (clr_win) begin
                win_cnt <= '0;
            end else if (step && blank_done) begin
                win_cnt <= fire ? '0 : win_nxt;
            end
        end
    end
endmodule

// File: rtl/pdet_sync_search.sv
module pdet_sync_search #(
    parameter int SYNC_BYTES = 4,
    parameter int LEN_W      = 9,
    parameter int SETTLE     = pdet_pkg::SETTLE_BITS,
    localparam int SYNC_W = 8 * SYNC_BYTES,
    localparam int SBW    = $clog2(SYNC_BYTES),
    localparam int CNT_W  = LEN_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic              bit_in,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [SBW-1:0]    sync_bytes,
    input  logic [LEN_W-1:0]  pre_len,
    output logic              match,
    output logic              expire
);
    logic [SYNC_W-1:0] sr;
    logic [SYNC_W-1:0] sr_nxt;
    logic [SYNC_W-1:0] mask;
    logic [SYNC_W-1:0] pattern;
    logic [CNT_W-1:0]  tcnt;
    logic [CNT_W-1:0]  limit;
    int                drop;

    always_comb begin
        drop    = SYNC_W - 8 * (int'(sync_bytes) + 1);
        sr_nxt  = {sr[SYNC_W-2:0], bit_in};
        mask    = {SYNC_W{1'b1}} >> drop;
        pattern = sync_word >> drop;
        limit   = CNT_W'({pre_len, 2'b00}) + CNT_W'(SETTLE);
        match   = step && ((sr_nxt & mask) == pattern);
        expire  = step && !match && ((tcnt + 1'b1) == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr   <= '0;
            tcnt <= '0;
        end else if (step) begin
            sr   <= sr_nxt;
            tcnt <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/preamble_detect.sv
module preamble_detect #(
    parameter int THR_W      = 5,
    parameter int LEN_W      = 9,
    parameter int SYNC_BYTES = 4,
    localparam int SYNC_W = 8 * SYNC_BYTES,
    localparam int SBW    = $clog2(SYNC_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              pkt_done,
    input  logic [THR_W-1:0]  thr_nib,
    input  logic [LEN_W-1:0]  pre_len_nib,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [SBW-1:0]    sync_bytes,
    output logic              pre_valid,
    output logic              sync_found,
    output logic              valid_irq,
    output logic              invalid_irq,
    output logic              sync_irq,
    output logic              timeout_irq
);
    import pdet_pkg::*;

    pdet_state_e state, state_nxt;
    pdet_evt_t   evt, evt_q;
    logic        hit, fire, match, expire;
    logic        in_search, in_wait;

    assign in_search = (state == ST_SEARCH);
    assign in_wait   = (state == ST_SYNC_WAIT);

    pdet_run_counter #(.THR_W(THR_W)) i_run (
        .clk    (clk),
        .rst    (rst),
        .clr    (!in_search),
        .step   (bit_vld && in_search),
        .bit_in (bit_in),
        .thr    (thr_nib),
        .hit    (hit)
    );

    pdet_window #(.THR_W(THR_W), .SETTLE(SETTLE_BITS)) i_win (
        .clk     (clk),
        .rst     (rst),
        .clr_all (state == ST_IDLE),
        .clr_win (!in_search || hit),
        .strobe  (bit_vld),
        .step    (bit_vld && in_search),
        .thr     (thr_nib),
        .fire    (fire)
    );

    pdet_sync_search #(.SYNC_BYTES(SYNC_BYTES), .LEN_W(LEN_W), .SETTLE(SETTLE_BITS)) i_sync (
        .clk        (clk),
        .rst        (rst),
        .clr        (!in_wait),
        .step       (bit_vld && in_wait),
        .bit_in     (bit_in),
        .sync_word  (sync_word),
        .sync_bytes (sync_bytes),
        .pre_len    (pre_len_nib),
        .match      (match),
        .expire     (expire)
    );

    always_comb begin
        state_nxt = state;
        evt       = '0;
        if (!rx_en) begin
            state_nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: state_nxt = ST_SEARCH;
                ST_SEARCH: begin
                    if (hit) begin
                        state_nxt = ST_SYNC_WAIT;
                        evt.valid = 1'b1;
                    end else if (fire) begin
                        evt.invalid = 1'b1;
                    end
                end
                ST_SYNC_WAIT: begin
                    if (match) begin
                        state_nxt = ST_SYNC_FOUND;
                        evt.sync  = 1'b1;
                    end else if (expire) begin
                        state_nxt   = ST_SEARCH;
                        evt.timeout = 1'b1;
                    end
                end
                ST_SYNC_FOUND: begin
                    if (pkt_done) state_nxt = ST_SEARCH;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            evt_q      <= '0;
            pre_valid  <= 1'b0;
            sync_found <= 1'b0;
        end else begin
            state      <= state_nxt;
            evt_q      <= evt;
            pre_valid  <= (state_nxt == ST_SYNC_WAIT);
            sync_found <= (state_nxt == ST_SYNC_FOUND);
        end
    end

    assign valid_irq   = evt_q.valid;
    assign invalid_irq = evt_q.invalid;
    assign sync_irq    = evt_q.sync;
    assign timeout_irq = evt_q.timeout;
endmodule

// File: rtl/pdet_checker.sv
module pdet_checker (
    input logic clk,
    input logic rst,
    input logic rx_en,
    input logic bit_vld,
    input logic pre_valid,
    input logic sync_found,
    input logic valid_irq,
    input logic invalid_irq,
    input logic sync_irq,
    input logic timeout_irq
);
    logic [5:0] strobes_since_en;
    logic       any_irq;

    assign any_irq = valid_irq || invalid_irq || sync_irq || timeout_irq;

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            strobes_since_en <= '0;
        end else if (bit_vld && strobes_since_en != 6'h3f) begin
            strobes_since_en <= strobes_since_en + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!pre_valid && !sync_found && !any_irq)); // R1
    AST_LEVELS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pre_valid && sync_found)); // R6
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(pre_valid) |-> valid_irq); // R2
    AST_BLANKING: assert property (@(posedge clk) disable iff (rst)
        invalid_irq |-> (strobes_since_en > 6'd16)); // R4
    AST_SYNC_LEVEL: assert property (@(posedge clk) disable iff (rst)
        sync_irq |-> (sync_found && !pre_valid)); // R6
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(pre_valid) |-> (sync_irq || timeout_irq || !$past(rx_en))); // R7
    AST_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        any_irq |-> $past(bit_vld)); // R9
    AST_PULSE_VALID: assert property (@(posedge clk) disable iff (rst)
        valid_irq |=> !valid_irq); // R10
    AST_PULSE_INVALID: assert property (@(posedge clk) disable iff (rst)
        invalid_irq |=> !invalid_irq); // R10
    AST_PULSE_SYNC: assert property (@(posedge clk) disable iff (rst)
        sync_irq |=> !sync_irq); // R10
    AST_PULSE_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        timeout_irq |=> !timeout_irq); // R10
endmodule

bind preamble_detect pdet_checker i_pdet_checker (
    .clk         (clk),
    .rst         (rst),
    .rx_en       (rx_en),
    .bit_vld     (bit_vld),
    .pre_valid   (pre_valid),
    .sync_found  (sync_found),
    .valid_irq   (valid_irq),
    .invalid_irq (invalid_irq),
    .sync_irq    (sync_irq),
    .timeout_irq (timeout_irq)
);

// File: tb/test_preamble_detect.sv
module test_preamble_detect;
    typedef struct packed {
        logic [4:0] thr;
        logic [8:0] plen;
        logic [1:0] sb;
        logic [7:0] prebits;
        logic       with_sync;
    } scen_t;

    localparam scen_t SCEN [4] = '{
        '{thr: 5'd2, plen: 9'd4, sb: 2'd1, prebits: 8'd16, with_sync: 1'b1},
        '{thr: 5'd4, plen: 9'd8, sb: 2'd0, prebits: 8'd20, with_sync: 1'b1},
        '{thr: 5'd3, plen: 9'd2, sb: 2'd3, prebits: 8'd12, with_sync: 1'b0},
        '{thr: 5'd1, plen: 9'd8, sb: 2'd2, prebits: 8'd8,  with_sync: 1'b1}
    };
    localparam logic [31:0] SYNC_PAT = 32'h2DD4_3A5C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic        pkt_done = 1'b0;
    logic [4:0]  thr_nib = 5'd2;
    logic [8:0]  pre_len_nib = 9'd4;
    logic [31:0] sync_word = SYNC_PAT;
    logic [1:0]  sync_bytes = 2'd1;
    logic        pre_valid, sync_found, valid_irq, invalid_irq, sync_irq, timeout_irq;

    int n_chk = 0;
    int n_bad = 0;
    int idx, v_at, v_cnt, s_at, t_at, i_cnt, i_first;

    always #5 clk = ~clk;

    preamble_detect i_preamble_detect (
        .clk(clk), .rst(rst), .rx_en(rx_en), .bit_vld(bit_vld), .bit_in(bit_in),
        .pkt_done(pkt_done), .thr_nib(thr_nib), .pre_len_nib(pre_len_nib),
        .sync_word(sync_word), .sync_bytes(sync_bytes), .pre_valid(pre_valid),
        .sync_found(sync_found), .valid_irq(valid_irq), .invalid_irq(invalid_irq),
        .sync_irq(sync_irq), .timeout_irq(timeout_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        idx = 0; v_at = 0; v_cnt = 0; s_at = 0; t_at = 0; i_cnt = 0; i_first = 0;
    endtask

    task automatic sample();
        if (valid_irq) begin v_at = idx; v_cnt++; end
        if (sync_irq) s_at = idx;
        if (timeout_irq) t_at = idx;
        if (invalid_irq) begin
            if (i_cnt == 0) i_first = idx;
            i_cnt++;
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        @(posedge clk);
        #1;
        bit_vld = 1'b0;
        idx++;
        sample();
    endtask

    task automatic quiet_cycle();
        @(posedge clk);
        #1;
        sample();
    endtask

    task automatic restart_rx();
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        clear_log();
    endtask

    task automatic run_scen(input scen_t s);
        int nb;
        thr_nib = s.thr; pre_len_nib = s.plen; sync_bytes = s.sb;
        nb = int'(s.sb) + 1;
        restart_rx();
        for (int i = 0; i < int'(s.prebits); i++) send_bit((i % 2) == 0);
        if (s.with_sync) begin
            for (int k = 0; k < nb; k++)
                for (int j = 7; j >= 0; j--) send_bit(SYNC_PAT[31 - 8*k - (7 - j)]);
            check("R6 sync strobe index", s_at, int'(s.prebits) + 8*nb);
            check("R6 sync_found level", int'(sync_found), 1);
            check("R6 pre_valid cleared", int'(pre_valid), 0);
        end else begin
            for (int i = 0; i < 4*int'(s.plen) + 40 && t_at == 0; i++) send_bit(1'b0);
            check("R7 timeout strobe index", t_at, 4*int'(s.thr) + 4*int'(s.plen) + 16);
            check("R7 pre_valid dropped", int'(pre_valid), 0);
        end
        check("R2 detection strobe index", v_at, 4*int'(s.thr));
        check("R10 single valid pulse", v_cnt, 1);
        check("R4 no invalid pulse in scenario", i_cnt, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_log();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset pre_valid", int'(pre_valid), 0);
        check("R1 reset sync_found", int'(sync_found), 0);
        check("R1 reset pulses", int'(valid_irq | invalid_irq | sync_irq | timeout_irq), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < 4; i++) run_scen(SCEN[i]);

        // R8: scenario table ends in sync_found; end of packet clears it
        @(negedge clk); pkt_done = 1'b1;
        @(negedge clk); pkt_done = 1'b0;
        check("R8 sync_found cleared by pkt_done", int'(sync_found), 0);

        // R4 / R5: no alternation at all, threshold 2 nibbles
        thr_nib = 5'd2; pre_len_nib = 9'd2; sync_bytes = 2'd1;
        restart_rx();
        for (int i = 0; i < 32; i++) send_bit(1'b0);
        check("R4 first invalid after settling", i_first, 24);
        check("R5 invalid pulse count", i_cnt, 2);

        // R3: repeated bit restarts the run
        restart_rx();
        begin
            logic [11:0] seq;
            seq = 12'b1010_0101_0101;
            for (int i = 11; i >= 0; i--) send_bit(seq[i]);
        end
        check("R3 detection after restarted run", v_at, 12);

        // R9: gap without strobes, bit_in toggling
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); bit_in = ~bit_in;
            quiet_cycle();
            n_chk++;
            if (pre_valid !== 1'b1 || timeout_irq || sync_irq) begin
                n_bad++;
                $display("FAIL R9 gap changed outputs: actual pre_valid %0d expected 1", pre_valid);
            end
        end
        for (int i = 0; i < 40 && t_at == 0; i++) send_bit(1'b0);
        check("R9 timeout unaffected by gap", t_at, 12 + 4*2 + 16);

        // R1: enable drop while waiting for sync
        restart_rx();
        for (int i = 0; i < 8; i++) send_bit((i % 2) == 0);
        check("R2 detection before drop", int'(pre_valid), 1);
        @(negedge clk); rx_en = 1'b0;
        @(posedge clk); #1;
        check("R1 pre_valid after enable drop", int'(pre_valid), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule